// File: doc/BRIEF.md
# Indirect Offset Address Generator

This block produces data-memory addresses for an 8-bit microcontroller whose instructions carry a 9-bit operand field. When the top bit of that field is set, the operand lives at a base pointer plus a small unsigned displacement taken from the field. A second field bit chooses which base is used: a data pointer or a stack pointer. Both pointers are 12 bits wide and are held inside the block.

The data pointer is written one byte at a time from an 8-bit immediate. The stack pointer is moved only by push and pop. Push uses the current top-of-stack slot and then moves the pointer down. Pop moves the pointer up and uses the new slot. On either operation an offset-mode operand address is still formed from the stack pointer value held before the update.

All address outputs are combinational from the current inputs and the pointer registers. Pointer updates land on the next rising clock edge. The block accepts one operation per cycle and never stalls, so it has no valid/ready handshake. Its pins are plain control and status.

Top module: `iwo_agen`

## Requirements
- R1: `ea_vld` equals operand bit 8. When that bit is 0, `ea_addr` is zero.
- R2: When operand bit 8 is 1, `ea_addr` is the selected base plus the unsigned value of operand bits 6:0, modulo 4096.
- R3: Operand bit 7 picks the base. A 0 picks the data pointer and a 1 picks the stack pointer.
- R4: Op code 1 (load high) writes imm bits 3:0 into data pointer bits 11:8 at the next edge. Imm bits 7:4 are discarded, and the low byte keeps its value.
- R5: Op code 2 (load low) writes imm into data pointer bits 7:0 at the next edge, and the high part keeps its value.
- R6: Op code 3 (push) drives `slot_addr` with the current stack pointer and raises `slot_vld`. An offset operand on the stack pointer uses the current value. The stack pointer drops by one at the next edge.
- R7: Op code 4 (pop) drives `slot_addr` with the stack pointer plus one and raises `slot_vld`. An offset operand on the stack pointer uses the value before the increment. The stack pointer rises by one at the next edge.
- R8: Stack pointer increment and decrement wrap modulo 4096 (0 minus 1 gives 0xFFF, and 0xFFF plus 1 gives 0).
- R9: A synchronous active-high reset clears both pointers. For op codes 0 (idle) and 5 to 7, neither pointer changes. For every op other than push and pop, `slot_vld` is 0 and `slot_addr` is zero.
- R10: The load ops never change the stack pointer, and push and pop never change the data pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code: 0 idle, 1 load high, 2 load low, 3 push, 4 pop |
| fr | input | 9 | Instruction operand field |
| imm | input | 8 | Immediate byte for the pointer loads |
| ea_addr | output | 12 | Operand effective address |
| ea_vld | output | 1 | Offset addressing active for this operand |
| slot_addr | output | 12 | Top-of-stack slot address for push or pop |
| slot_vld | output | 1 | Slot address meaningful this cycle |
| dp_val | output | 12 | Current data pointer |
| sp_val | output | 12 | Current stack pointer |

## Verification
A corrupted pointer register shows on `dp_val` or `sp_val` in the cycle after the bad update. The same error then appears on `ea_addr` in every cycle where offset mode selects that pointer. A fault in the stack-pointer ordering shows in the same cycle as the push or pop: either the operand address or the slot address comes out one off from the other. Sweeping every operand field value against a few pointer states exposes a wrong select bit, a wrong offset width or a missed wrap at once on `ea_addr`.

// File: rtl/iwo_pkg.sv
package iwo_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 3'd0,
    OP_LDHI = 3'd1,
    OP_LDLO = 3'd2,
    OP_PUSH = 3'd3,
    OP_POP  = 3'd4
  } op_e;
endpackage

// File: rtl/iwo_ptr_regs.sv
module iwo_ptr_regs
  import iwo_pkg::*;
#(
  parameter int PTR_W = 12,
  parameter int IMM_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    op,
  input  logic [IMM_W-1:0]   imm,
  output logic [PTR_W-1:0]   dp_q,
  output logic [PTR_W-1:0]   sp_q
);
  localparam int HI_W = PTR_W - IMM_W;

  logic [PTR_W-1:0] dp_nxt;
  logic [PTR_W-1:0] sp_nxt;

  generate
    if (HI_W > 0) begin : g_split
      always_comb begin
        dp_nxt = dp_q;
        if (op == OP_LDHI) dp_nxt[PTR_W-1:IMM_W] = imm[HI_W-1:0];
        if (op == OP_LDLO) dp_nxt[IMM_W-1:0]     = imm;
      end
    end else begin : g_single
      always_comb begin
        dp_nxt = dp_q;
        if (op == OP_LDLO) dp_nxt = imm[PTR_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    sp_nxt = sp_q;
    if (op == OP_PUSH) sp_nxt = sp_q - PTR_W'(1);
    if (op == OP_POP)  sp_nxt = sp_q + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_q <= '0;
      sp_q <= '0;
    end else begin
      dp_q <= dp_nxt;
      sp_q <= sp_nxt;
    end
  end
endmodule

// File: rtl/iwo_ea_calc.sv
module iwo_ea_calc #(
  parameter int PTR_W = 12,
  parameter int FR_W  = 9
) (
  input  logic [FR_W-1:0]  fr,
  input  logic [PTR_W-1:0] dp,
  input  logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] ea,
  output logic             ea_vld
);
  localparam int MODE_BIT = FR_W - 1;
  localparam int SEL_BIT  = FR_W - 2;
  localparam int OFF_W    = FR_W - 2;

  logic [PTR_W-1:0] base;
  logic [PTR_W-1:0] off_ext;

  assign base    = fr[SEL_BIT] ? sp : dp;
  assign off_ext = {{(PTR_W-OFF_W){1'b0}}, fr[OFF_W-1:0]};
  assign ea_vld  = fr[MODE_BIT];
  assign ea      = ea_vld ? (base + off_ext) : '0;
endmodule

// File: rtl/iwo_stack_slot.sv
module iwo_stack_slot
  import iwo_pkg::*;
#(
  parameter int PTR_W = 12
) (
  input  logic [OP_W-1:0]  op,
  input  logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] slot,
  output logic             slot_vld
);
  always_comb begin
    slot     = '0;
    slot_vld = 1'b0;
    if (op == OP_PUSH) begin
      slot     = sp;
      slot_vld = 1'b1;
    end else if (op == OP_POP) begin
      slot     = sp + PTR_W'(1);
      slot_vld = 1'b1;
    end
  end
endmodule

// File: rtl/iwo_agen.sv
module iwo_agen
  import iwo_pkg::*;
#(
  parameter int PTR_W = 12,
  parameter int IMM_W = 8,
  parameter int FR_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    op,
  input  logic [FR_W-1:0]    fr,
  input  logic [IMM_W-1:0]   imm,
  output logic [PTR_W-1:0]   ea_addr,
  output logic               ea_vld,
  output logic [PTR_W-1:0]   slot_addr,
  output logic               slot_vld,
  output logic [PTR_W-1:0]   dp_val,
  output logic [PTR_W-1:0]   sp_val
);
  logic [PTR_W-1:0] dp_w;
  logic [PTR_W-1:0] sp_w;

  iwo_ptr_regs #(.PTR_W(PTR_W), .IMM_W(IMM_W)) u_ptr (
    .clk (clk), .rst (rst), .op (op), .imm (imm),
    .dp_q(dp_w), .sp_q(sp_w)
  );

  iwo_ea_calc #(.PTR_W(PTR_W), .FR_W(FR_W)) u_ea (
    .fr(fr), .dp(dp_w), .sp(sp_w), .ea(ea_addr), .ea_vld(ea_vld)
  );

  iwo_stack_slot #(.PTR_W(PTR_W)) u_slot (
    .op(op), .sp(sp_w), .slot(slot_addr), .slot_vld(slot_vld)
  );

  assign dp_val = dp_w;
  assign sp_val = sp_w;
endmodule

// File: rtl/iwo_agen_chk.sv
module iwo_agen_chk
  import iwo_pkg::*;
#(
  parameter int PTR_W = 12,
  parameter int IMM_W = 8,
  parameter int FR_W  = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [OP_W-1:0]    op,
  input logic [FR_W-1:0]    fr,
  input logic [IMM_W-1:0]   imm,
  input logic [PTR_W-1:0]   ea_addr,
  input logic               ea_vld,
  input logic [PTR_W-1:0]   slot_addr,
  input logic               slot_vld,
  input logic [PTR_W-1:0]   dp_val,
  input logic [PTR_W-1:0]   sp_val
);
  localparam int OFF_W = FR_W - 2;
  logic [PTR_W-1:0] off_c;
  assign off_c = {{(PTR_W-OFF_W){1'b0}}, fr[OFF_W-1:0]};

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
    !fr[FR_W-1] |-> (!ea_vld && ea_addr == '0)); // R1

  AST_DP_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (fr[FR_W-1] && !fr[FR_W-2]) |-> ea_addr == PTR_W'(dp_val + off_c)); // R3

  AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> sp_val == PTR_W'($past(sp_val) - 1)); // R6

  AST_POP_UP: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> sp_val == PTR_W'($past(sp_val) + 1)); // R7

  AST_POP_SLOT: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |-> (slot_vld && slot_addr == PTR_W'(sp_val + 1))); // R7

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op != OP_PUSH && op != OP_POP) |=> $stable(sp_val)); // R10

  AST_DP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op != OP_LDHI && op != OP_LDLO) |=> $stable(dp_val)); // R9

  AST_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    (op != OP_PUSH && op != OP_POP) |-> (!slot_vld && slot_addr == '0)); // R9
endmodule

bind iwo_agen iwo_agen_chk #(.PTR_W(PTR_W), .IMM_W(IMM_W), .FR_W(FR_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .fr(fr), .imm(imm),
  .ea_addr(ea_addr), .ea_vld(ea_vld), .slot_addr(slot_addr),
  .slot_vld(slot_vld), .dp_val(dp_val), .sp_val(sp_val)
);

// File: tb/sim_iwo_agen.sv
`timescale 1ns/1ps
module sim_iwo_agen;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [8:0]  fr;
  logic [7:0]  imm;
  logic [11:0] ea_addr, slot_addr, dp_val, sp_val;
  logic        ea_vld, slot_vld;

  int total = 0;
  int bad   = 0;
  logic [11:0] m_dp, m_sp;
  logic [2:0]  prev_op;

  always #2.5 clk = ~clk;

  iwo_agen u0 (
    .clk(clk), .rst(rst), .op(op), .fr(fr), .imm(imm),
    .ea_addr(ea_addr), .ea_vld(ea_vld), .slot_addr(slot_addr),
    .slot_vld(slot_vld), .dp_val(dp_val), .sp_val(sp_val)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [8:0] f, input logic [7:0] im);
    logic [11:0] base, e_ea, e_slot;
    logic        e_sv;
    string       pt, et, st;
    @(negedge clk);
    op = o; fr = f; imm = im;
    #1;
    case (prev_op)
      3'd1: pt = "R4";
      3'd2: pt = "R5";
      3'd3: pt = (m_sp == 12'hFFF) ? "R8" : "R6";
      3'd4: pt = (m_sp == 12'h000) ? "R8" : "R7";
      3'd0: pt = "R9";
      default: pt = "R9";
    endcase
    chk(pt, "dp_val", dp_val, m_dp);
    chk((prev_op == 3'd1 || prev_op == 3'd2) ? "R10" : pt, "sp_val", sp_val, m_sp);
    base = f[7] ? m_sp : m_dp;
    e_ea = f[8] ? 12'((base + f[6:0]) % 4096) : 12'h000;
    if (!f[8])                      et = "R1";
    else if (f[7] && o == 3'd3)     et = "R6";
    else if (f[7] && o == 3'd4)     et = "R7";
    else if (f[7])                  et = "R3";
    else                            et = "R2";
    chk(et, "ea_addr", ea_addr, e_ea);
    chk("R1", "ea_vld", ea_vld, f[8]);
    if (o == 3'd3)      begin e_slot = m_sp;          e_sv = 1'b1; st = "R6"; end
    else if (o == 3'd4) begin e_slot = 12'(m_sp + 1); e_sv = 1'b1; st = "R7"; end
    else                begin e_slot = 12'h000;       e_sv = 1'b0; st = "R9"; end
    chk(st, "slot_addr", slot_addr, e_slot);
    chk(st, "slot_vld", slot_vld, e_sv);
    @(posedge clk);
    case (o)
      3'd1: m_dp[11:8] = im[3:0];
      3'd2: m_dp[7:0]  = im;
      3'd3: m_sp = 12'(m_sp - 1);
      3'd4: m_sp = 12'(m_sp + 1);
      default: ;
    endcase
    prev_op = o;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; op = 3'd0; fr = 9'd0; imm = 8'd0;
    m_dp = 12'h000; m_sp = 12'h000; prev_op = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "reset dp", dp_val, 12'h000);
    chk("R9", "reset sp", sp_val, 12'h000);
    rst = 1'b0;

    step(3'd1, 9'h000, 8'hF3);            // R4 upper imm bits dropped
    step(3'd2, 9'h000, 8'h8D);            // R5
    step(3'd0, 9'h108, 8'h00);            // R2 0x38D + 8
    for (int i = 0; i < 512; i++) step(3'd0, 9'(i), 8'h5A);

    step(3'd3, 9'h185, 8'h00);            // R6 push at 0, wraps R8
    step(3'd4, 9'h182, 8'h00);            // R7 pop from 0xFFF, ea wraps
    for (int i = 0; i < 5; i++) step(3'd3, 9'h180 | 9'(i), 8'h00);
    for (int i = 0; i < 5; i++) step(3'd4, 9'h190 | 9'(i), 8'h00);
    step(3'd3, 9'h0AA, 8'h00);            // push with direct operand
    step(3'd4, 9'h07F, 8'h00);

    for (int k = 5; k < 8; k++) step(3'(k), 9'h1FF, 8'hAA); // R9
    step(3'd0, 9'h000, 8'hAA);

    step(3'd1, 9'h000, 8'h0F);
    step(3'd2, 9'h000, 8'hF0);
    for (int i = 256; i < 512; i++) step(3'd0, 9'(i), 8'h00);
    for (int i = 0; i < 3; i++) step(3'd3, 9'h17F, 8'h00);
    for (int i = 256; i < 512; i += 7) step(3'd0, 9'(i), 8'h00);
    step(3'd1, 9'h000, 8'hA5);
    step(3'd0, 9'h000, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule